// File: doc/BRIEF.md
# Sector Address Sequencer and Checker

This block walks the disk address through a multi-sector transfer. A cylinder, head and sector are loaded once. Each step request then checks the current position against the geometry of the selected drive and the state of that drive. A step that passes produces a linear sector number and moves the position one sector forward, carrying into the head at the end of a track. A step that fails reports exactly one error class and leaves the position where it was, so the surrounding controller can stop the transfer. The caller supplies a first-sector flag. With it, a head that is out of range at the very start of a transfer is told apart from a head that runs off the last surface partway through.

A separate combinational path fills out a 256-byte sector buffer when fewer bytes were supplied. Reads are filled with zeros. Writes are filled by repeating the last byte that was supplied.

Top module: `sas_seq`

## Requirements
- R1: After reset no result strobe is high, and the current sector and current head both read 0.
- R2: The result of a step appears in the cycle after `step_i`. In that cycle `done_o` is high together with exactly one of `ok_o`, `err_xfer_o`, `err_wprot_o`, `err_acf_o` and `err_cyo_o`. A step in the same cycle as `load_i` is dropped: the load takes effect and no result is produced.
- R3: A passing step outputs `addr_o = (cyl*surfaces + head)*64 + sector`. The drive type selects the geometry: 0 gives 1 surface, 1 gives 3, 2 and 3 give 5, and 4 gives 19, all with 823 cylinders; 5 gives 16 surfaces with 1024 cylinders.
- R4: A step reported as `ok_o`, or as the write-protect result of a format command that passed its address check, advances the sector modulo 64. When the sector wraps to 0 the head increments. Any other result leaves the position unchanged.
- R5: If the command code is valid and the drive is not attached, the step reports `err_xfer_o`.
- R6: A write (code 0x02) to a write-protected drive reports `err_wprot_o`. A read (0x01) or read check (0x03) on a protected drive is not affected.
- R7: A cylinder at or above the cylinder count reports `err_xfer_o` together with `seek_inc_o`. Drive types 6 and 7 have zero cylinders, so every step on them fails this way.
- R8: A head at or above the surface count, when `first_i` is high, reports `err_acf_o` together with `unsafe_o`.
- R9: The same head fault with `first_i` low reports `err_cyo_o`, and `unsafe_o` stays low.
- R10: Format commands (codes 0x04 to 0x07) go through the full address check. If the check passes they report `err_wprot_o`; if it fails they report the address error.
- R11: Command codes outside 0x01 to 0x07 report `err_xfer_o`, whatever the drive state.
- R12: For a read, buffer byte positions at or above the supplied count are filled with 0x00. Positions below the count pass the supplied byte through.
- R13: For a write, buffer byte positions at or above the supplied count are filled with the last supplied byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load a start position |
| cyl_i | input | 12 | Start cylinder |
| head_i | input | 5 | Start head |
| sect_i | input | 6 | Start sector |
| step_i | input | 1 | Check and advance one sector |
| cmd_i | input | 6 | Command code |
| attached_i | input | 1 | Drive is attached |
| wprot_i | input | 1 | Drive is write protected |
| first_i | input | 1 | Step is the first sector of the transfer |
| dtype_i | input | 3 | Drive type, selects geometry |
| done_o | output | 1 | Step result is valid |
| ok_o | output | 1 | Sector passed |
| err_xfer_o | output | 1 | Transfer error |
| err_wprot_o | output | 1 | Write-protect result |
| err_acf_o | output | 1 | Address compare failure |
| err_cyo_o | output | 1 | Cylinder overflow |
| seek_inc_o | output | 1 | Drive seek incomplete |
| unsafe_o | output | 1 | Drive unsafe |
| addr_o | output | 25 | Linear sector address |
| cur_sect_o | output | 6 | Current sector |
| cur_head_o | output | 5 | Current head |
| pad_idx_i | input | 8 | Buffer byte position |
| pad_cnt_i | input | 9 | Number of bytes supplied, 0 to 256 |
| pad_src_i | input | 8 | Supplied byte at this position |
| pad_last_i | input | 8 | Last supplied byte |
| pad_wr_i | input | 1 | Buffer is for a write |
| pad_byte_o | output | 8 | Filled buffer byte |

## Verification
Passing reads are run on two geometries: a five-surface drive at a mid-disk position and the 1024-cylinder drive near its top. These show that the surface count and the shift by 64 enter the address correctly. Positions at sector 63 show the head carry. A walk off the last surface with the first-sector flag high and then low separates the address compare failure from cylinder overflow. The error stimuli include a detached drive, protection on a write and on a read, a cylinder equal to the limit, unknown drive types, format codes with a good and a bad address, and an unsupported code. Together they exercise each branch of the priority order. The fill path is driven at positions below, at and above the count, in read and in write mode.

// File: rtl/sas_pkg.sv
package sas_pkg;
  localparam logic [5:0] CMD_READ  = 6'h01;
  localparam logic [5:0] CMD_WRITE = 6'h02;
  localparam logic [5:0] CMD_RCHK  = 6'h03;
  localparam logic [5:0] CMD_FMT_LO = 6'h04;
  localparam logic [5:0] CMD_FMT_HI = 6'h07;

  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_XFER  = 3'd1,
    RES_WPROT = 3'd2,
    RES_ACF   = 3'd3,
    RES_CYO   = 3'd4
  } res_e;
endpackage

// File: rtl/sas_geom.sv
module sas_geom #(
  parameter int DTYPE_W = 3,
  parameter int CYL_W   = 12,
  parameter int HEAD_W  = 5
) (
  input  logic [DTYPE_W-1:0] dtype_i,
  output logic [HEAD_W:0]    surf_o,
  output logic [CYL_W:0]     cyls_o
);
  always_comb begin
    surf_o = '0;
    cyls_o = '0;
    case (dtype_i)
      DTYPE_W'(0): begin surf_o = (HEAD_W+1)'(1);  cyls_o = (CYL_W+1)'(823);  end
      DTYPE_W'(1): begin surf_o = (HEAD_W+1)'(3);  cyls_o = (CYL_W+1)'(823);  end
      DTYPE_W'(2): begin surf_o = (HEAD_W+1)'(5);  cyls_o = (CYL_W+1)'(823);  end
      DTYPE_W'(3): begin surf_o = (HEAD_W+1)'(5);  cyls_o = (CYL_W+1)'(823);  end
      DTYPE_W'(4): begin surf_o = (HEAD_W+1)'(19); cyls_o = (CYL_W+1)'(823);  end
      DTYPE_W'(5): begin surf_o = (HEAD_W+1)'(16); cyls_o = (CYL_W+1)'(1024); end
      default: ;  // zero geometry: every access fails the cylinder check
    endcase
  end
endmodule

// File: rtl/sas_check.sv
module sas_check
  import sas_pkg::*;
#(
  parameter int CYL_W  = 12,
  parameter int HEAD_W = 5,
  parameter int SECT_W = 6,
  parameter int ADDR_W = 25
) (
  input  logic [5:0]        cmd_i,
  input  logic              attached_i,
  input  logic              wprot_i,
  input  logic              first_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [HEAD_W:0]   surf_i,
  input  logic [CYL_W:0]    cyls_i,
  output res_e              res_o,
  output logic              seek_inc_o,
  output logic              unsafe_o,
  output logic              adv_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic cmd_fmt, cmd_xfer, cyl_bad, head_bad;

  assign cmd_fmt  = (cmd_i >= CMD_FMT_LO) && (cmd_i <= CMD_FMT_HI);
  assign cmd_xfer = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE) || (cmd_i == CMD_RCHK);
  assign cyl_bad  = {1'b0, cyl_i} >= cyls_i;
  assign head_bad = {1'b0, head_i} >= surf_i;

  assign addr_o = ((ADDR_W'(cyl_i) * ADDR_W'(surf_i) + ADDR_W'(head_i)) << SECT_W)
                  + ADDR_W'(sect_i);

  always_comb begin
    res_o      = RES_OK;
    seek_inc_o = 1'b0;
    unsafe_o   = 1'b0;
    adv_o      = 1'b0;
    if (!(cmd_fmt || cmd_xfer)) begin
      res_o = RES_XFER;
    end else if (!attached_i) begin
      res_o = RES_XFER;
    end else if (wprot_i && cmd_i == CMD_WRITE) begin
      res_o = RES_WPROT;
    end else if (cyl_bad) begin
      res_o      = RES_XFER;
      seek_inc_o = 1'b1;
    end else if (head_bad) begin
      res_o    = first_i ? RES_ACF : RES_CYO;
      unsafe_o = first_i;
    end else begin
      adv_o = 1'b1;
      res_o = cmd_fmt ? RES_WPROT : RES_OK;
    end
  end
endmodule

// File: rtl/sas_pos.sv
module sas_pos #(
  parameter int CYL_W  = 12,
  parameter int HEAD_W = 5,
  parameter int SECT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic              adv_i,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [SECT_W-1:0] sect_o
);
  logic [SECT_W-1:0] sect_nx;
  assign sect_nx = sect_o + SECT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_o  <= '0;
      head_o <= '0;
      sect_o <= '0;
    end else if (load_i) begin
      cyl_o  <= cyl_i;
      head_o <= head_i;
      sect_o <= sect_i;
    end else if (adv_i) begin
      sect_o <= sect_nx;
      if (sect_nx == '0) head_o <= head_o + HEAD_W'(1);
    end
  end
endmodule

// File: rtl/sas_pad.sv
module sas_pad #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W:0]   cnt_i,
  input  logic [7:0]       src_i,
  input  logic [7:0]       last_i,
  input  logic             wr_i,
  output logic [7:0]       byte_o
);
  always_comb begin
    if ({1'b0, idx_i} < cnt_i) byte_o = src_i;
    else if (wr_i)             byte_o = last_i;
    else                       byte_o = 8'h00;
  end
endmodule

// File: rtl/sas_seq.sv
module sas_seq
  import sas_pkg::*;
#(
  parameter int DTYPE_W = 3,
  parameter int CYL_W   = 12,
  parameter int HEAD_W  = 5,
  parameter int SECT_W  = 6,
  parameter int IDX_W   = 8,
  localparam int ADDR_W = CYL_W + HEAD_W + 1 + SECT_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CYL_W-1:0]   cyl_i,
  input  logic [HEAD_W-1:0]  head_i,
  input  logic [SECT_W-1:0]  sect_i,
  input  logic               step_i,
  input  logic [5:0]         cmd_i,
  input  logic               attached_i,
  input  logic               wprot_i,
  input  logic               first_i,
  input  logic [DTYPE_W-1:0] dtype_i,
  output logic               done_o,
  output logic               ok_o,
  output logic               err_xfer_o,
  output logic               err_wprot_o,
  output logic               err_acf_o,
  output logic               err_cyo_o,
  output logic               seek_inc_o,
  output logic               unsafe_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [SECT_W-1:0]  cur_sect_o,
  output logic [HEAD_W-1:0]  cur_head_o,
  input  logic [IDX_W-1:0]   pad_idx_i,
  input  logic [IDX_W:0]     pad_cnt_i,
  input  logic [7:0]         pad_src_i,
  input  logic [7:0]         pad_last_i,
  input  logic               pad_wr_i,
  output logic [7:0]         pad_byte_o
);
  logic [HEAD_W:0]   surf;
  logic [CYL_W:0]    cyls;
  logic [CYL_W-1:0]  cur_cyl;
  res_e              res;
  logic              seek_inc, unsafe, adv, step_go;
  logic [ADDR_W-1:0] addr_c;

  assign step_go = step_i && !load_i;

  sas_geom #(.DTYPE_W(DTYPE_W), .CYL_W(CYL_W), .HEAD_W(HEAD_W)) u_geom (
    .dtype_i(dtype_i), .surf_o(surf), .cyls_o(cyls)
  );

  sas_check #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W), .ADDR_W(ADDR_W)) u_check (
    .cmd_i(cmd_i), .attached_i(attached_i), .wprot_i(wprot_i), .first_i(first_i),
    .cyl_i(cur_cyl), .head_i(cur_head_o), .sect_i(cur_sect_o),
    .surf_i(surf), .cyls_i(cyls),
    .res_o(res), .seek_inc_o(seek_inc), .unsafe_o(unsafe), .adv_o(adv), .addr_o(addr_c)
  );

  sas_pos #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .cyl_i(cyl_i), .head_i(head_i), .sect_i(sect_i),
    .adv_i(step_go && adv),
    .cyl_o(cur_cyl), .head_o(cur_head_o), .sect_o(cur_sect_o)
  );

  sas_pad #(.IDX_W(IDX_W)) u_pad (
    .idx_i(pad_idx_i), .cnt_i(pad_cnt_i), .src_i(pad_src_i),
    .last_i(pad_last_i), .wr_i(pad_wr_i), .byte_o(pad_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      ok_o        <= 1'b0;
      err_xfer_o  <= 1'b0;
      err_wprot_o <= 1'b0;
      err_acf_o   <= 1'b0;
      err_cyo_o   <= 1'b0;
      seek_inc_o  <= 1'b0;
      unsafe_o    <= 1'b0;
      addr_o      <= '0;
    end else begin
      done_o      <= step_go;
      ok_o        <= step_go && res == RES_OK;
      err_xfer_o  <= step_go && res == RES_XFER;
      err_wprot_o <= step_go && res == RES_WPROT;
      err_acf_o   <= step_go && res == RES_ACF;
      err_cyo_o   <= step_go && res == RES_CYO;
      seek_inc_o  <= step_go && seek_inc;
      unsafe_o    <= step_go && unsafe;
      if (step_go && adv) addr_o <= addr_c;
    end
  end
endmodule

// File: rtl/sas_seq_chk.sv
module sas_seq_chk #(
  parameter int HEAD_W = 5,
  parameter int SECT_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              step_i,
  input logic              done_o,
  input logic              ok_o,
  input logic              err_xfer_o,
  input logic              err_wprot_o,
  input logic              err_acf_o,
  input logic              err_cyo_o,
  input logic              seek_inc_o,
  input logic              unsafe_o,
  input logic [SECT_W-1:0] cur_sect_o,
  input logic [HEAD_W-1:0] cur_head_o
);
  logic [4:0] res_vec;
  assign res_vec = {ok_o, err_xfer_o, err_wprot_o, err_acf_o, err_cyo_o};

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(res_vec) == 1); // R2
  AST_NO_STRAY_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> res_vec == '0); // R2
  AST_DONE_FROM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(step_i && !load_i)); // R2
  AST_SECT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> cur_sect_o == $past(cur_sect_o) + SECT_W'(1)); // R4
  AST_HEAD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && cur_sect_o == '0) |-> cur_head_o == $past(cur_head_o) + HEAD_W'(1)); // R4
  AST_ERR_HOLDS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_xfer_o || err_acf_o || err_cyo_o) |-> ($stable(cur_sect_o) && $stable(cur_head_o))); // R4
  AST_SEEK_WITH_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seek_inc_o |-> err_xfer_o); // R7
  AST_UNSAFE_WITH_ACF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsafe_o |-> err_acf_o); // R8
endmodule

bind sas_seq sas_seq_chk #(.HEAD_W(HEAD_W), .SECT_W(SECT_W)) u_chk (.*);

// File: tb/sas_seq_tb.sv
module sas_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [11:0] cyl_i = '0;
  logic [4:0]  head_i = '0;
  logic [5:0]  sect_i = '0;
  logic        step_i = 1'b0;
  logic [5:0]  cmd_i = 6'h01;
  logic        attached_i = 1'b1;
  logic        wprot_i = 1'b0;
  logic        first_i = 1'b1;
  logic [2:0]  dtype_i = '0;
  logic        done_o, ok_o, err_xfer_o, err_wprot_o, err_acf_o, err_cyo_o;
  logic        seek_inc_o, unsafe_o;
  logic [24:0] addr_o;
  logic [5:0]  cur_sect_o;
  logic [4:0]  cur_head_o;
  logic [7:0]  pad_idx_i = '0;
  logic [8:0]  pad_cnt_i = '0;
  logic [7:0]  pad_src_i = '0;
  logic [7:0]  pad_last_i = '0;
  logic        pad_wr_i = 1'b0;
  logic [7:0]  pad_byte_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  sas_seq u_dut (.*);

  function automatic int surf_of(int dt);
    case (dt)
      0: return 1; 1: return 3; 2: return 5; 3: return 5; 4: return 19; 5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int lin(int dt, int c, int h, int s);
    return (c * surf_of(dt) + h) * 64 + s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result vector order: ok, xfer, wprot, acf, cyo, seek_inc, unsafe
  function automatic int res_vec();
    return {ok_o, err_xfer_o, err_wprot_o, err_acf_o, err_cyo_o, seek_inc_o, unsafe_o};
  endfunction

  task automatic load(int c, int h, int s);
    @(negedge clk_i);
    load_i = 1'b1; cyl_i = 12'(c); head_i = 5'(h); sect_i = 6'(s);
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic step(int cmd, bit att, bit wp, bit first, int dt);
    @(negedge clk_i);
    cmd_i = 6'(cmd); attached_i = att; wprot_i = wp; first_i = first; dtype_i = 3'(dt);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 done", done_o, 0);
    check("R1 results", res_vec(), 0);
    check("R1 sector", cur_sect_o, 0);
    check("R1 head", cur_head_o, 0);
  endtask

  task automatic t_read_basic();
    load(100, 2, 10);
    step(1, 1, 0, 1, 3);
    check("R2 done", done_o, 1);
    check("R3 ok only", res_vec(), 7'b1000000);
    check("R3 addr type3", addr_o, lin(3, 100, 2, 10));
    check("R4 sector inc", cur_sect_o, 11);
    check("R4 head same", cur_head_o, 2);
    @(negedge clk_i);
    check("R2 single pulse", done_o, 0);
  endtask

  task automatic t_wrap();
    load(7, 1, 63);
    step(1, 1, 0, 1, 2);
    check("R3 addr at 63", addr_o, lin(2, 7, 1, 63));
    check("R4 wrap sector", cur_sect_o, 0);
    check("R4 head carry", cur_head_o, 2);
  endtask

  task automatic t_big_geom();
    load(1000, 15, 5);
    step(1, 1, 0, 1, 5);
    check("R3 type5 ok", res_vec(), 7'b1000000);
    check("R3 addr type5", addr_o, lin(5, 1000, 15, 5));
  endtask

  task automatic t_detached();
    load(10, 0, 4);
    step(1, 0, 0, 1, 3);
    check("R5 xfer", res_vec(), 7'b0100000);
    check("R4 no advance", cur_sect_o, 4);
  endtask

  task automatic t_wprot();
    load(10, 0, 4);
    step(2, 1, 1, 1, 3);
    check("R6 write protect", res_vec(), 7'b0010000);
    check("R6 no advance", cur_sect_o, 4);
    step(1, 1, 1, 1, 3);
    check("R6 read unaffected", res_vec(), 7'b1000000);
    check("R6 read advanced", cur_sect_o, 5);
  endtask

  task automatic t_bad_cyl();
    load(823, 0, 0);
    step(1, 1, 0, 1, 0);
    check("R7 cyl limit", res_vec(), 7'b0100010);
    load(0, 0, 0);
    step(1, 1, 0, 1, 6);
    check("R7 type6", res_vec(), 7'b0100010);
    step(1, 1, 0, 1, 7);
    check("R7 type7", res_vec(), 7'b0100010);
    check("R7 no advance", cur_sect_o, 0);
  endtask

  task automatic t_head_fault();
    load(3, 5, 9);
    step(1, 1, 0, 1, 2);
    check("R8 acf unsafe", res_vec(), 7'b0001001);
    step(1, 1, 0, 0, 2);
    check("R9 cyo", res_vec(), 7'b0000100);
    check("R9 no advance", cur_sect_o, 9);
    // run off the single surface of type 0
    load(4, 0, 63);
    step(2, 1, 0, 1, 0);
    check("R4 last sector ok", res_vec(), 7'b1000000);
    check("R4 carried head", cur_head_o, 1);
    step(2, 1, 0, 0, 0);
    check("R9 overflow later", res_vec(), 7'b0000100);
  endtask

  task automatic t_format();
    load(20, 1, 30);
    step(5, 1, 0, 1, 3);
    check("R10 fmt pass wprot", res_vec(), 7'b0010000);
    check("R10 fmt advanced", cur_sect_o, 31);
    step(4, 1, 0, 1, 3);
    check("R10 fmt 0x04", res_vec(), 7'b0010000);
    step(7, 1, 0, 1, 3);
    check("R10 fmt 0x07", res_vec(), 7'b0010000);
    load(900, 0, 0);
    step(6, 1, 0, 1, 3);
    check("R10 fmt bad cyl", res_vec(), 7'b0100010);
  endtask

  task automatic t_bad_cmd();
    load(1, 0, 2);
    step(0, 1, 0, 1, 3);
    check("R11 code 0", res_vec(), 7'b0100000);
    step(8, 1, 0, 1, 3);
    check("R11 code 8", res_vec(), 7'b0100000);
    check("R11 no advance", cur_sect_o, 2);
  endtask

  task automatic t_load_blocks_step();
    @(negedge clk_i);
    load_i = 1'b1; cyl_i = 12'd5; head_i = 5'd0; sect_i = 6'd40;
    cmd_i = 6'h01; attached_i = 1'b1; wprot_i = 1'b0; dtype_i = 3'd3; step_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    check("R2 step dropped", done_o, 0);
    check("R2 load taken", cur_sect_o, 40);
  endtask

  task automatic t_pad();
    pad_src_i = 8'hA5; pad_last_i = 8'h3C; pad_cnt_i = 9'd100;
    pad_wr_i = 1'b0; pad_idx_i = 8'd50; #1;
    check("R12 read data kept", pad_byte_o, 8'hA5);
    pad_idx_i = 8'd100; #1;
    check("R12 read zero at cnt", pad_byte_o, 8'h00);
    pad_idx_i = 8'd255; #1;
    check("R12 read zero tail", pad_byte_o, 8'h00);
    pad_wr_i = 1'b1; pad_idx_i = 8'd200; #1;
    check("R13 write last fill", pad_byte_o, 8'h3C);
    pad_idx_i = 8'd99; #1;
    check("R13 write data kept", pad_byte_o, 8'hA5);
    pad_cnt_i = 9'd256; pad_idx_i = 8'd255; #1;
    check("R13 full buffer", pad_byte_o, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_read_basic();
    t_wrap();
    t_big_geom();
    t_detached();
    t_wprot();
    t_bad_cyl();
    t_head_fault();
    t_format();
    t_bad_cmd();
    t_load_blocks_step();
    t_pad();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule